// File: doc/BRIEF.md
# Two-Slot Edge Capture Unit

This block takes a snapshot of a free-running counter, supplied from outside, whenever a chosen transition appears on an external pin. It has two snapshot slots, and they fill in a fixed order. The first qualifying transition lands in the first slot and the next one lands in the second slot. After both slots are full, the unit ignores further transitions until its slot index is cleared.

A single-cycle event pulse marks the moment that matters to the interrupt logic. A select input chooses that moment: the event follows the first snapshot or the second one. The pin is treated as asynchronous. It passes through two synchronizing flops, and a third flop keeps the previous level so that transitions can be detected.

The slot index returns to zero in two cases: software acknowledges the capture status, or capture is switched on from the disabled mode. The counter, the register decode and the interrupt controller all sit outside this block.

Top module: `edge_snap_unit`

## Requirements
- R1: `edge_mode` selects the qualifying transition. 0 disables capture, 1 selects low-to-high, 2 selects high-to-low, and 3 selects either direction.
- R2: The first qualifying transition after an index reset stores `cnt_in` into `snap_a`, and the second stores it into `snap_b`. Any further transitions leave both slots unchanged until the index is reset again.
- R3: `snap_evt` is high for exactly one cycle. It follows the first snapshot when `evt_on_second` is 0 and the second snapshot when `evt_on_second` is 1. Any other snapshot produces no pulse.
- R4: While `pin_is_input` is 0, pin transitions store nothing and raise no event.
- R5: A cycle with `ack_snap` high returns the slot index to zero, so the next qualifying transition fills `snap_a`.
- R6: A change of `edge_mode` from 0 to any nonzero value returns the slot index to zero.
- R7: After reset, `snap_a` and `snap_b` read 0 and `snap_evt` is 0.
- R8: If an index reset and a qualifying transition fall on the same cycle, the reset wins. The transition is dropped and both slots keep their values.
- R9: A pin change that is stable before clock edge k is stored, with `snap_evt` asserted, at edge k+2. The stored value is the `cnt_in` value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | CNT_W | External counter value to snapshot |
| pin_in | input | 1 | Asynchronous capture pin |
| pin_is_input | input | 1 | 1 when the pin is configured as an input |
| edge_mode | input | 2 | Transition select (0 none, 1 rise, 2 fall, 3 both) |
| evt_on_second | input | 1 | 0: event on first snapshot, 1: event on second |
| ack_snap | input | 1 | Single-cycle status acknowledge; clears the slot index |
| snap_a | output | CNT_W | First snapshot slot |
| snap_b | output | CNT_W | Second snapshot slot |
| snap_evt | output | 1 | Single-cycle capture event |

## Verification
The slot index is hidden, so a wrong index shows up at the ports only at the next qualifying transition. That transition lands in the wrong slot, or it is ignored when it should be stored, and `snap_evt` pulses at the wrong snapshot. Each scenario therefore follows every index-changing action (acknowledge, mode re-enable, same-cycle collision) with a fresh transition, and reads both slots and the event three cycles later. A wrong level in the previous-level flop shows at the very next pin change, as a missed or spurious snapshot.

// File: rtl/edge_snap_unit.sv
module edge_snap_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             pin_in,
  input  logic             pin_is_input,
  input  logic [1:0]       edge_mode,
  input  logic             evt_on_second,
  input  logic             ack_snap,
  output logic [CNT_W-1:0] snap_a,
  output logic [CNT_W-1:0] snap_b,
  output logic             snap_evt
);

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_RISE = 2'd1;
  localparam logic [1:0] MODE_FALL = 2'd2;
  localparam logic [1:0] SLOTS     = 2'd2;

  logic       sync1, sync2, lvl_q;
  logic [1:0] mode_q;
  logic [1:0] idx;
  logic       hit, take, idx_clear;

  wire rise = sync2 & ~lvl_q;
  wire fall = ~sync2 & lvl_q;

  always_comb begin
    case (edge_mode)
      MODE_OFF:  hit = 1'b0;
      MODE_RISE: hit = rise;
      MODE_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
  end

  assign idx_clear = ack_snap | ((mode_q == MODE_OFF) && (edge_mode != MODE_OFF));
  assign take      = pin_is_input & hit & (idx != SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      lvl_q    <= 1'b0;
      mode_q   <= MODE_OFF;
      idx      <= 2'd0;
      snap_a   <= '0;
      snap_b   <= '0;
      snap_evt <= 1'b0;
    end else begin
      sync1    <= pin_in;
      sync2    <= sync1;
      lvl_q    <= sync2;
      mode_q   <= edge_mode;
      snap_evt <= 1'b0;
      if (idx_clear) begin
        idx <= 2'd0;
      end else if (take) begin
        if (idx == 2'd0) snap_a <= cnt_in;
        else             snap_b <= cnt_in;
        idx      <= idx + 2'd1;
        snap_evt <= (idx[0] == evt_on_second);
      end
    end
  end

  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= SLOTS);

  assert_slot_a_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap_a) |-> (idx == 2'd1));

  assert_slot_b_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap_b) |-> (idx == SLOTS));

  assert_evt_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    snap_evt |-> (idx == ({1'b0, $past(evt_on_second)} + 2'd1)));

  assert_dir_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_is_input |=> ($stable(snap_a) && $stable(snap_b) && !snap_evt));

  assert_mode_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode == MODE_OFF) |=> ($stable(snap_a) && $stable(snap_b) && !snap_evt));

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_snap |=> (idx == 2'd0));

  assert_ack_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_snap |=> ($stable(snap_a) && $stable(snap_b) && !snap_evt));

endmodule

// File: tb/tb_edge_snap_unit.sv
module tb_edge_snap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt_in = '0;
  logic        pin_in = 1'b0;
  logic        pin_is_input = 1'b1;
  logic [1:0]  edge_mode = 2'd1;
  logic        evt_on_second = 1'b0;
  logic        ack_snap = 1'b0;
  logic [31:0] snap_a, snap_b;
  logic        snap_evt;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_snap_unit #(.CNT_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .pin_in(pin_in),
    .pin_is_input(pin_is_input), .edge_mode(edge_mode),
    .evt_on_second(evt_on_second), .ack_snap(ack_snap),
    .snap_a(snap_a), .snap_b(snap_b), .snap_evt(snap_evt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [31:0] c);
    @(negedge clk);
    pin_in = v;
    cnt_in = c;
    repeat (3) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); ack_snap = 1'b1;
    @(negedge clk); ack_snap = 1'b0;
  endtask

  task automatic t_reset();
    check("R7 snap_a", snap_a, 0);
    check("R7 snap_b", snap_b, 0);
    check("R7 evt", {31'd0, snap_evt}, 0);
  endtask

  task automatic t_rise_order();
    drive(1'b1, 32'h100);
    check("R9 R2 snap_a", snap_a, 32'h100);
    check("R3 evt first", {31'd0, snap_evt}, 1);
    @(negedge clk);
    check("R3 evt one cycle", {31'd0, snap_evt}, 0);
    drive(1'b0, 32'h200);
    check("R1 fall ignored in rise", snap_b, 0);
    drive(1'b1, 32'h300);
    check("R2 snap_b", snap_b, 32'h300);
    check("R3 no evt on second", {31'd0, snap_evt}, 0);
    drive(1'b0, 32'h350);
    drive(1'b1, 32'h400);
    check("R2 third ignored a", snap_a, 32'h100);
    check("R2 third ignored b", snap_b, 32'h300);
  endtask

  task automatic t_ack();
    ack();
    drive(1'b0, 32'h450);
    drive(1'b1, 32'h500);
    check("R5 refill snap_a", snap_a, 32'h500);
    check("R5 evt", {31'd0, snap_evt}, 1);
  endtask

  task automatic t_fall_second();
    @(negedge clk); edge_mode = 2'd2; evt_on_second = 1'b1;
    ack();
    drive(1'b0, 32'h600);
    check("R1 fall snap_a", snap_a, 32'h600);
    check("R3 no evt on first", {31'd0, snap_evt}, 0);
    drive(1'b1, 32'h650);
    check("R1 rise ignored in fall", snap_b, 32'h300);
    drive(1'b0, 32'h700);
    check("R2 fall snap_b", snap_b, 32'h700);
    check("R3 evt on second", {31'd0, snap_evt}, 1);
  endtask

  task automatic t_both();
    @(negedge clk); edge_mode = 2'd3; evt_on_second = 1'b0;
    ack();
    drive(1'b1, 32'h800);
    check("R1 both rise", snap_a, 32'h800);
    drive(1'b0, 32'h900);
    check("R1 both fall", snap_b, 32'h900);
  endtask

  task automatic t_dir();
    ack();
    @(negedge clk); pin_is_input = 1'b0;
    drive(1'b1, 32'hA00);
    check("R4 no snap", snap_a, 32'h800);
    check("R4 no evt", {31'd0, snap_evt}, 0);
    drive(1'b0, 32'hA80);
    check("R4 no snap", snap_a, 32'h800);
    @(negedge clk); pin_is_input = 1'b1;
  endtask

  task automatic t_reenable();
    drive(1'b1, 32'hB00);
    drive(1'b0, 32'hC00);
    check("R2 fill b", snap_b, 32'hC00);
    @(negedge clk); edge_mode = 2'd0;
    drive(1'b1, 32'hC80);
    check("R1 mode off", snap_a, 32'hB00);
    check("R1 mode off evt", {31'd0, snap_evt}, 0);
    @(negedge clk); edge_mode = 2'd3;
    @(negedge clk);
    drive(1'b0, 32'hD00);
    check("R6 reenable refill", snap_a, 32'hD00);
  endtask

  task automatic t_prio();
    ack();
    @(negedge clk); pin_in = 1'b1; cnt_in = 32'hE00;
    @(negedge clk);
    @(negedge clk); ack_snap = 1'b1;
    @(negedge clk); ack_snap = 1'b0;
    check("R8 edge dropped a", snap_a, 32'hD00);
    check("R8 no evt", {31'd0, snap_evt}, 0);
    repeat (2) @(negedge clk);
    check("R8 not retried", snap_a, 32'hD00);
    drive(1'b0, 32'hF00);
    check("R8 index reset", snap_a, 32'hF00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rise_order();
    t_ack();
    t_fall_second();
    t_both();
    t_dir();
    t_reenable();
    t_prio();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule